// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a link to a 16-bit-word serial EEPROM that uses chip select, a serial clock, a serial data line toward the memory and a serial data line back from it. A client hands it one command at a time. There are four commands: read a burst of words, write one word, allow programming and forbid programming. The controller forms the serial frame itself. A read streams the returned words out on a valid/ready port. A write waits for the memory's self-timed programming to finish by watching the return line. Every command ends with a one-cycle done pulse and an error flag.

Each frame opens with a start bit of 1, then a 2-bit code, then the address, all sent MSB first. Data toward the memory changes only when the serial clock falls. The clock half period comes from a parameter in system cycles. Chip select always stays low for a parameterised minimum before it rises again. That minimum applies between frames, and it also applies between the end of a write frame and the start of status polling.

States and transitions of the controller:
- ST_IDLE goes to ST_GAP when a command is accepted.
- ST_GAP raises chip select once the low-time minimum is met, then goes to ST_SHIFT.
- ST_SHIFT clocks the frame out. After the last bit:
  - a read goes to ST_RDATA;
  - a write goes to ST_WGAP;
  - the other two commands go to ST_FINISH.
- ST_RDATA goes to ST_DRAIN after the last word of the burst.
- ST_DRAIN goes to ST_IDLE once the last word has been taken.
- ST_WGAP raises chip select after the minimum low time, then goes to ST_POLL.
- ST_POLL goes to ST_FINISH when the return line reads 1, or when the wait times out.
- ST_FINISH goes to ST_IDLE.

Top module: `mw_host`

## Requirements
- R1: A command is taken only in a cycle where cmd_valid and cmd_ready are both high. cmd_ready is high only when the controller is idle, and cmd_valid has no effect while a command is in progress.
- R2: Each frame starts with a 1 bit, followed by the code (read 10, write 01, allow/forbid programming 00) and then the ADDR_W address bits, all MSB first. ee_di is stable on every rising edge of ee_sk and changes only after a falling edge.
- R3: Allow-programming sends code 00 and then an address field whose two top bits are 11 and whose other bits are 0. Forbid-programming sends code 00 and an all-zero address field. Command encoding on cmd_op: 0 read, 1 write, 2 allow, 3 forbid.
- R4: On a read, the bit returned during the last address bit is the memory's 0 placeholder and is discarded. Each later group of 16 bits forms one word, MSB first.
- R5: A read burst returns cmd_len words (a value of 0 means one word) from a single frame, continuing from address to address upward. After the top address the memory wraps to address 0.
- R6: rd_data is held stable while rd_valid is high and rd_ready is low. The serial clock pauses so that no word is lost.
- R7: A write sends the 16 data bits MSB first after the address. Chip select then drops, stays low for the minimum, rises again, and ee_do is watched until it reads 1.
- R8: Chip select stays low for at least CS_LOW_MIN system cycles before every rise, including the first rise after reset.
- R9: ee_sk is high for HALF_DIV cycles and low for HALF_DIV cycles while clocking. ee_sk is low whenever chip select is low.
- R10: If ee_do has not read 1 within BUSY_MAX cycles of polling, the command completes with timeout_err = 1. Otherwise timeout_err = 0 at done.
- R11: done is a one-cycle pulse at the end of each command, and cmd_ready is high from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_op | input | 2 | 0 read, 1 write, 2 allow, 3 forbid |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Word to write |
| cmd_len | input | LEN_W | Words in a read burst (0 means 1) |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Consumer takes the read word |
| rd_data | output | DATA_W | Read word |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Busy wait timed out, valid with done |
| ee_cs | output | 1 | Chip select to memory |
| ee_sk | output | 1 | Serial clock to memory |
| ee_di | output | 1 | Serial data to memory |
| ee_do | input | 1 | Serial data from memory |

## Verification
Results have the following timing:
- A read word appears one cycle after the falling-edge strobe of its sixteenth bit, and stays until taken.
- done comes one cycle after the last word is taken, or one cycle after chip select drops at the end of the frame or the poll.
- cmd_ready falls on the cycle after acceptance.

The bench does not count fixed latencies for the data. It queues the expected words when it issues a command and pops one at every valid/ready handshake, sampling on the falling system edge. It waits on done before checking each command's outcome, and samples one further edge later for the pulse width. Interval monitors measure the chip-select low time and the serial clock high time in whole cycles on every transition.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WREN  = 2'd2,
        OP_WRDIS = 2'd3
    } mw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_GAP, ST_SHIFT, ST_RDATA,
        ST_DRAIN, ST_WGAP, ST_POLL, ST_FINISH
    } mw_state_e;
endpackage

// File: rtl/mw_clkgen.sv
`timescale 1ns/1ps
module mw_clkgen #(
    parameter int HALF_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic stall,
    output logic sk,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          sk_q;
    logic          wrap;

    assign wrap     = run && !stall && (cnt_q == LAST);
    assign rise_stb = wrap && !sk_q;
    assign fall_stb = wrap && sk_q;
    assign sk       = sk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sk_q  <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            sk_q  <= 1'b0;
        end else if (!stall) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                sk_q  <= ~sk_q;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    AST_SK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> !sk_q) else $error("sk not parked low"); // R9
endmodule

// File: rtl/mw_rxword.sv
`timescale 1ns/1ps
module mw_rxword #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word,
    output logic              full
);
    localparam int CW = $clog2(DATA_W);

    logic [DATA_W-1:0] sr_q;
    logic [CW-1:0]     cnt_q;

    assign word = {sr_q[DATA_W-2:0], bit_in};
    assign full = shift_en && (cnt_q == CW'(DATA_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (shift_en) begin
            sr_q  <= word;
            cnt_q <= full ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/mw_host.sv
`timescale 1ns/1ps
module mw_host
    import mw_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int LEN_W      = 8,
    parameter int HALF_DIV   = 100,
    parameter int CS_LOW_MIN = 50,
    parameter int BUSY_MAX   = 1600000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              timeout_err,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int HDR_W = 3 + ADDR_W;
    localparam int TX_W  = HDR_W + DATA_W;
    localparam int BC_W  = $clog2(TX_W + 1);
    localparam int GAP_W = $clog2(CS_LOW_MIN + 1);
    localparam int TO_W  = $clog2(BUSY_MAX + 1);

    mw_state_e         state_q, state_d;
    mw_op_e            op_q;
    logic [TX_W-1:0]   tx_q, tx_load;
    logic [BC_W-1:0]   bits_q, nbits_q;
    logic [LEN_W-1:0]  words_q;
    logic [GAP_W-1:0]  gap_q;
    logic [TO_W-1:0]   to_q;
    logic              cs_q, rd_valid_q, done_q, err_q;
    logic [DATA_W-1:0] rd_data_q;

    logic sk_run, sk_stall, rise_stb, fall_stb, sk_w;
    logic rx_full;
    logic [DATA_W-1:0] rx_word;
    logic gap_ok, last_bit, last_word, tmo, accept;

    assign gap_ok    = (gap_q == GAP_W'(CS_LOW_MIN));
    assign last_bit  = (bits_q == nbits_q - BC_W'(1));
    assign last_word = (words_q == LEN_W'(1));
    assign tmo       = (to_q == TO_W'(BUSY_MAX - 1));
    assign accept    = (state_q == ST_IDLE) && cmd_valid;
    assign sk_run    = cs_q && ((state_q == ST_SHIFT) || (state_q == ST_RDATA));
    assign sk_stall  = rd_valid_q && !rd_ready;

    mw_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(sk_run), .stall(sk_stall),
        .sk(sk_w), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mw_rxword #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(state_q == ST_SHIFT),
        .shift_en((state_q == ST_RDATA) && fall_stb), .bit_in(ee_do),
        .word(rx_word), .full(rx_full)
    );

    // frame image: start bit, code, address field, data
    always_comb begin
        unique case (mw_op_e'(cmd_op))
            OP_READ:  tx_load = {3'b110, cmd_addr, {DATA_W{1'b0}}};
            OP_WRITE: tx_load = {3'b101, cmd_addr, cmd_wdata};
            OP_WREN:  tx_load = {3'b100, 2'b11, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
            OP_WRDIS: tx_load = {3'b100, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
            default:  tx_load = '0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = ST_GAP;
            ST_GAP:    if (gap_ok) state_d = ST_SHIFT;
            ST_SHIFT:  if (fall_stb && last_bit)
                           state_d = (op_q == OP_READ)  ? ST_RDATA :
                                     (op_q == OP_WRITE) ? ST_WGAP  : ST_FINISH;
            ST_RDATA:  if (rx_full && last_word) state_d = ST_DRAIN;
            ST_DRAIN:  if (!rd_valid_q || rd_ready) state_d = ST_IDLE;
            ST_WGAP:   if (gap_ok) state_d = ST_POLL;
            ST_POLL:   if (ee_do || tmo) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_READ;
            tx_q       <= '0;
            bits_q     <= '0;
            nbits_q    <= '0;
            words_q    <= '0;
            gap_q      <= '0;
            to_q       <= '0;
            cs_q       <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            gap_q  <= cs_q ? '0 : (gap_ok ? gap_q : gap_q + GAP_W'(1));
            to_q   <= (state_q == ST_POLL) ? to_q + TO_W'(1) : '0;
            done_q <= (state_q == ST_FINISH) ||
                      ((state_q == ST_DRAIN) && (!rd_valid_q || rd_ready));
            if (rd_valid_q && rd_ready) rd_valid_q <= 1'b0;
            if (accept) begin
                op_q    <= mw_op_e'(cmd_op);
                tx_q    <= tx_load;
                bits_q  <= '0;
                nbits_q <= (mw_op_e'(cmd_op) == OP_WRITE) ? BC_W'(TX_W) : BC_W'(HDR_W);
                words_q <= (cmd_len == '0) ? LEN_W'(1) : cmd_len;
                err_q   <= 1'b0;
            end
            if (((state_q == ST_GAP) || (state_q == ST_WGAP)) && gap_ok)
                cs_q <= 1'b1;
            if ((state_q == ST_SHIFT) && fall_stb) begin
                tx_q   <= tx_q << 1;
                bits_q <= bits_q + BC_W'(1);
                if (last_bit && (op_q != OP_READ)) cs_q <= 1'b0;
            end
            if ((state_q == ST_RDATA) && rx_full) begin
                rd_valid_q <= 1'b1;
                rd_data_q  <= rx_word;
                words_q    <= words_q - LEN_W'(1);
                if (last_word) cs_q <= 1'b0;
            end
            if ((state_q == ST_POLL) && (ee_do || tmo)) begin
                cs_q  <= 1'b0;
                err_q <= !ee_do;
            end
        end
    end

    assign cmd_ready   = (state_q == ST_IDLE);
    assign rd_valid    = rd_valid_q;
    assign rd_data     = rd_data_q;
    assign done        = done_q;
    assign timeout_err = err_q;
    assign ee_cs       = cs_q;
    assign ee_sk       = sk_w;
    assign ee_di       = (state_q == ST_SHIFT) && tx_q[TX_W-1];

    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk) else $error("sk high with cs low"); // R9
    AST_DI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> $stable(ee_di)) else $error("di moved at sk rise"); // R2
    AST_CS_LOW_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> $past(gap_q) == GAP_W'(CS_LOW_MIN)) else $error("cs low too short"); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)) else $error("read word dropped"); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R11
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready) else $error("done while busy"); // R11
    AST_NO_SK_IN_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL) |-> !ee_sk) else $error("clocking during poll"); // R7
endmodule

// File: tb/mw_host_tb.sv
`timescale 1ns/1ps
module mw_host_tb;
    localparam int AW   = 10;
    localparam int DW   = 16;
    localparam int LW   = 8;
    localparam int HD   = 8;
    localparam int GAP  = 50;
    localparam int BMAX = 3000;
    localparam int HDRB = 2 + AW;
    localparam int SRW  = HDRB + DW;
    localparam int NW   = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic cmd_valid = 1'b0, cmd_ready, rd_valid, rd_ready = 1'b1, done, timeout_err;
    logic [1:0] cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0, rd_data;
    logic [LW-1:0] cmd_len = '0;
    logic ee_cs, ee_sk, ee_di, ee_do;

    mw_host #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .HALF_DIV(HD),
              .CS_LOW_MIN(GAP), .BUSY_MAX(BMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .timeout_err(timeout_err),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, n_pop = 0, busy_t = 300;
    bit bp = 1'b0, ended = 1'b0;
    logic [DW-1:0] ref_mem [NW];
    logic [DW-1:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DW-1:0] mem [NW];
    logic [SRW-1:0] m_sr;
    logic [HDRB-1:0] m_hdr;
    logic [AW-1:0] m_raddr;
    logic [3:0] m_rbit;
    logic m_skp, m_csp, m_start, m_rd, m_do, m_en, m_stat, m_wpend, m_poll_busy;
    logic [DW-1:0] m_wdat;
    int m_cnt, m_busy, m_frames;

    assign ee_do = ee_cs & (m_rd ? m_do : (m_stat & (m_busy == 0)));

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem[i] <= 16'(i * 41) ^ 16'h5A3C;
            m_skp <= 0; m_csp <= 0; m_start <= 0; m_rd <= 0; m_do <= 0; m_en <= 0;
            m_stat <= 0; m_wpend <= 0; m_poll_busy <= 0; m_cnt <= 0; m_busy <= 0;
            m_frames <= 0; m_sr <= '0; m_hdr <= '0; m_raddr <= '0; m_rbit <= '0; m_wdat <= '0;
        end else begin
            m_skp <= ee_sk;
            m_csp <= ee_cs;
            if (m_busy > 0) m_busy <= m_busy - 1;
            if (ee_cs && !m_csp && m_stat && m_busy > 0) m_poll_busy <= 1;
            if (!ee_cs) begin
                if (m_csp && m_wpend) begin
                    m_busy <= busy_t;
                    mem[m_hdr[AW-1:0]] <= m_wdat;
                    m_wpend <= 0;
                end
                m_start <= 0; m_cnt <= 0; m_rd <= 0;
            end else if (ee_sk && !m_skp) begin
                if (!m_start) begin
                    if (ee_di) begin m_start <= 1; m_cnt <= 0; m_stat <= 0; m_sr <= '0; end
                end else if (m_rd) begin
                    m_do <= mem[m_raddr][4'd15 - m_rbit];
                    m_rbit <= m_rbit + 4'd1;
                    if (m_rbit == 4'd15) m_raddr <= m_raddr + 1'b1;
                end else begin
                    m_sr  <= {m_sr[SRW-2:0], ee_di};
                    m_cnt <= m_cnt + 1;
                    if (m_cnt == HDRB - 1) begin
                        logic [HDRB-1:0] h;
                        h = {m_sr[HDRB-2:0], ee_di};
                        m_hdr <= h;
                        m_frames <= m_frames + 1;
                        if (h[HDRB-1 -: 2] == 2'b10) begin
                            m_rd <= 1; m_do <= 0; m_raddr <= h[AW-1:0]; m_rbit <= 0;
                        end else if (h[HDRB-1 -: 2] == 2'b00) begin
                            if (h[AW-1 -: 2] == 2'b11) m_en <= 1;
                            else if (h[AW-1 -: 2] == 2'b00) m_en <= 0;
                        end
                    end
                    if (m_cnt == HDRB + DW - 1 && m_hdr[HDRB-1 -: 2] == 2'b01) begin
                        m_wdat  <= {m_sr[DW-2:0], ee_di};
                        m_wpend <= m_en;
                        m_stat  <= 1;
                    end
                end
            end
        end
    end

    // ---------------- monitors ----------------
    int lowcnt = 0, gap_viol = 0, hicnt = 0, sk_viol = 0;
    bit csp_n = 0, skp_n = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!ee_cs) lowcnt++;
            if (ee_cs && !csp_n) begin
                if (lowcnt < GAP) gap_viol++;
                lowcnt = 0;
            end
            if (ee_sk) hicnt++;
            if (!ee_sk && skp_n) begin
                if (hicnt != HD) sk_viol++;
                hicnt = 0;
            end
            csp_n = ee_cs; skp_n = ee_sk;
            rd_ready = bp ? ((cyc % 23) < 7) : 1'b1;
            if (rd_valid && rd_ready) begin
                n_pop++;
                if (exp_q.size() == 0) chk(0, "R4", "unexpected word", rd_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R4", "read word", rd_data, e);
                end
            end
        end
    end

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        wait (cyc > 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        summary();
    end

    // ---------------- driver ----------------
    task automatic issue(input int op, input int addr, input int wdata, input int len,
                         output bit err, output int took);
        int t0;
        while (!cmd_ready) @(negedge clk);
        cmd_op = op[1:0]; cmd_addr = addr[AW-1:0]; cmd_wdata = wdata[DW-1:0];
        cmd_len = len[LW-1:0]; cmd_valid = 1; t0 = cyc;
        @(negedge clk);
        cmd_valid = 0;
        chk(cmd_ready == 0, "R1", "cmd_ready busy", cmd_ready, 0);
        while (!done) @(negedge clk);
        err = timeout_err; took = cyc - t0;
        @(negedge clk);
        chk(!done && cmd_ready, "R11", "done pulse/ready", {done, cmd_ready}, 2'b01);
    endtask

    task automatic rd_burst(input int addr, input int len, input string req);
        bit e; int t, n0, nw;
        nw = (len == 0) ? 1 : len;
        for (int i = 0; i < nw; i++) exp_q.push_back(ref_mem[(addr + i) % NW]);
        n0 = n_pop;
        issue(0, addr, 0, len, e, t);
        chk(n_pop - n0 == nw, req, "burst word count", n_pop - n0, nw);
        chk(m_hdr == {2'b10, addr[AW-1:0]}, "R2", "read header", m_hdr, {2'b10, addr[AW-1:0]});
    endtask

    task automatic wr(input int addr, input int data, output bit err, output int took);
        bit en;
        en = m_en;
        issue(1, addr, data, 0, err, took);
        if (en) ref_mem[addr] = data[DW-1:0];
        chk(m_hdr == {2'b01, addr[AW-1:0]}, "R2", "write header", m_hdr, {2'b01, addr[AW-1:0]});
    endtask

    initial begin
        bit e; int t, f0;
        for (int i = 0; i < NW; i++) ref_mem[i] = 16'(i * 41) ^ 16'h5A3C;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!ee_cs && !ee_sk && cmd_ready && !rd_valid && !done, "R9", "reset state",
            {ee_cs, ee_sk, cmd_ready, rd_valid, done}, 5'b00100);

        // write while programming forbidden: memory keeps old word
        wr(20, 16'h1234, e, t);
        chk(e == 0, "R10", "no timeout when ready", e, 0);
        rd_burst(20, 1, "R4");

        issue(2, 0, 0, 0, e, t);
        chk(m_hdr == {2'b00, 2'b11, {(AW-2){1'b0}}}, "R3", "allow header",
            m_hdr, {2'b00, 2'b11, {(AW-2){1'b0}}});

        wr(20, 16'hBEEF, e, t);
        chk(e == 0, "R10", "write completes ok", e, 0);
        chk(t > (3 + AW + DW) * 2 * HD + busy_t, "R7", "waited for ready", t,
            (3 + AW + DW) * 2 * HD + busy_t);
        chk(m_poll_busy == 1, "R7", "poll began while busy", m_poll_busy, 1);
        rd_burst(20, 1, "R7");

        // R1: cmd_valid during a read must not start another frame
        f0 = m_frames;
        fork
            rd_burst(5, 3, "R5");
            begin
                repeat (60) @(negedge clk);
                cmd_op = 2'd3; cmd_valid = 1;
                repeat (10) @(negedge clk);
                cmd_valid = 0;
            end
        join
        chk(m_frames - f0 == 1, "R1", "ignored request", m_frames - f0, 1);
        chk(m_en == 1, "R1", "programming still allowed", m_en, 1);

        rd_burst(NW - 1, 2, "R5");
        rd_burst(100, 0, "R5");

        bp = 1;
        rd_burst(200, 4, "R6");
        bp = 0;

        busy_t = 6000;
        wr(30, 16'h0F0F, e, t);
        chk(e == 1, "R10", "timeout flagged", e, 1);
        busy_t = 300;

        issue(3, 0, 0, 0, e, t);
        chk(m_hdr == '0, "R3", "forbid header", m_hdr, 0);
        chk(m_en == 0, "R3", "programming forbidden", m_en, 0);
        rd_burst(30, 1, "R4");

        chk(exp_q.size() == 0, "R4", "all words returned", exp_q.size(), 0);
        chk(gap_viol == 0, "R8", "cs low time", gap_viol, 0);
        chk(sk_viol == 0, "R9", "sk high width", sk_viol, 0);
        summary();
    end
endmodule